// File: doc/BRIEF.md
# Boot Source Selection Controller

This block settles, once per reset, where the processor starts fetching code. A fixed number of clock edges after reset is released, it captures two boot-mode pins and a bank-boot option bit. Most pin and option combinations map straight to one boot target. In the remaining cases the block runs a dual-bank scan. It reads the first word of flash bank 2, then if needed the first word of flash bank 1. It judges each word to be a usable initial stack pointer only if it falls inside the internal SRAM window.

The result is a 3-bit target code, announced by a one-cycle done pulse. The code then holds until the next reset. Flash words are fetched through a plain request/acknowledge read port, and the memory behind that port may insert any number of wait cycles.

Top module: `boot_select_top`

## Requirements
- R1: When no memory scan is needed, `bootDone` is high for exactly one cycle: the cycle after the fifth rising edge following reset release. In every case `bootDone` pulses exactly once per reset, and `bootTarget` keeps its value from that pulse until reset.
- R2: `bootPin0`, `bootPin1` and `bankOptBit` are captured together on the fourth rising edge after reset release. Values they take before or after that edge have no effect on the result.
- R3: With the captured option bit at 1, the targets are as follows. Pin0=0 gives user flash (code 1) regardless of pin1. Pin1=0 with pin0=1 gives system memory (code 2). Pin1=1 with pin0=1 gives embedded SRAM (code 3).
- R4: With the option bit at 0, pin1=1 with pin0=1 gives embedded SRAM (code 3), and no memory read is issued.
- R5: With the option bit at 0 and any other pin pair, the first read goes to address `0x0808_0000`. If that word is valid, the target is jump-to-bank-2 (code 4), and no second read is made.
- R6: If the bank-2 word is invalid, a second read goes to address `0x0800_0000`. If that word is valid, the target is jump-to-bank-1 (code 5).
- R7: If both words are invalid, the target is system memory (code 2).
- R8: A word is valid when `SRAM_LO <= word < SRAM_HI`. The defaults are `0x2000_0000` and `0x2001_8000`. Zero is therefore invalid.
- R9: `memReq` is high only while a read is outstanding. It holds, with `memAddr` unchanged, until `memAck`, however many wait cycles pass.
- R10: `bootTarget` reads 0 (no target) until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootPin0 | input | 1 | Boot-mode pin 0 |
| bootPin1 | input | 1 | Boot-mode pin 1 |
| bankOptBit | input | 1 | Bank-boot option bit (0 enables the dual-bank scan) |
| memReq | output | 1 | Read request to flash |
| memAddr | output | 32 | Read address |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Read acknowledge, one cycle |
| bootTarget | output | 3 | 0 none, 1 user flash, 2 system memory, 3 SRAM, 4 bank 2, 5 bank 1 |
| bootDone | output | 1 | One-cycle pulse when the target is final |

## Verification
The closest pair of events is the acknowledge that rejects the bank-2 word and the launch of the bank-1 request. Both happen on the same edge: the request line stays high while the address swaps. The memory model runs with zero, one and two wait cycles, so the acknowledge sometimes lands on the very first request cycle. The bench logs every acknowledged address in order. It then judges the scan by the read sequence, the final code and a single done pulse. The sweep includes words sitting exactly on both window bounds.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [2:0] {
    TGT_NONE       = 3'd0,
    TGT_USER_FLASH = 3'd1,
    TGT_SYS_MEM    = 3'd2,
    TGT_SRAM       = 3'd3,
    TGT_BANK2      = 3'd4,
    TGT_BANK1      = 3'd5
  } bootTarget_e;

  typedef enum logic [1:0] {
    SRC_PINS   = 2'd0,
    SRC_BANK2  = 2'd1,
    SRC_BANK1  = 2'd2,
    SRC_SYSMEM = 2'd3
  } tgtSrc_e;

  typedef struct packed {
    logic    latchPins;
    logic    loadTarget;
    tgtSrc_e tgtSrc;
    logic    selBank2;
  } ctrlStrobe_t;

  // Direct pin mapping, used when no scan is run
  function automatic bootTarget_e pinTarget(input logic opt, input logic p1, input logic p0);
    if (p0 && p1)   return TGT_SRAM;
    else if (!opt)  return TGT_SYS_MEM;
    else if (!p0)   return TGT_USER_FLASH;
    else            return TGT_SYS_MEM;
  endfunction

endpackage

// File: rtl/boot_sel_dp.sv
module boot_sel_dp
  import boot_sel_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0808_0000,
  parameter logic [31:0] SRAM_LO    = 32'h2000_0000,
  parameter logic [31:0] SRAM_HI    = 32'h2001_8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              pin0In,
  input  logic              pin1In,
  input  logic              optIn,
  input  logic [DATA_W-1:0] rdata,
  output logic              pin0Q,
  output logic              pin1Q,
  output logic              optQ,
  output logic              wordValid,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        target
);

  localparam logic [DATA_W-1:0] LO_BOUND = DATA_W'(SRAM_LO);
  localparam logic [DATA_W-1:0] HI_BOUND = DATA_W'(SRAM_HI);

  bootTarget_e targetQ;

  // Pin and option capture, held until reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pin0Q <= 1'b0;
      pin1Q <= 1'b0;
      optQ  <= 1'b1;
    end else if (strobe.latchPins) begin
      pin0Q <= pin0In;
      pin1Q <= pin1In;
      optQ  <= optIn;
    end
  end

  // Stack-pointer plausibility: inside the SRAM window, upper bound excluded
  assign wordValid = (rdata >= LO_BOUND) && (rdata < HI_BOUND);

  assign addr = strobe.selBank2 ? ADDR_W'(BANK2_BASE) : ADDR_W'(BANK1_BASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= TGT_NONE;
    end else if (strobe.loadTarget) begin
      unique case (strobe.tgtSrc)
        SRC_PINS:   targetQ <= pinTarget(optQ, pin1Q, pin0Q);
        SRC_BANK2:  targetQ <= TGT_BANK2;
        SRC_BANK1:  targetQ <= TGT_BANK1;
        SRC_SYSMEM: targetQ <= TGT_SYS_MEM;
        default:    targetQ <= TGT_SYS_MEM;
      endcase
    end
  end

  assign target = targetQ;

endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
  import boot_sel_pkg::*;
#(
  parameter int LATCH_EDGE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pin0Q,
  input  logic        pin1Q,
  input  logic        optQ,
  input  logic        wordValid,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        bootDone
);

  localparam int CNT_W = $clog2(LATCH_EDGE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATCH_EDGE - 1);

  typedef enum logic [2:0] {
    ST_COUNT, ST_EVAL, ST_RD2, ST_RD1, ST_DONE, ST_HOLD
  } state_e;

  state_e          state, stateNext;
  logic [CNT_W-1:0] edgeCnt;
  logic            directSel;

  assign directSel = optQ || (pin0Q && pin1Q);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (state == ST_COUNT && edgeCnt != CNT_LAST) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_COUNT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext         = state;
    strobe.latchPins  = 1'b0;
    strobe.loadTarget = 1'b0;
    strobe.tgtSrc     = SRC_PINS;
    strobe.selBank2   = (state == ST_RD2);
    unique case (state)
      ST_COUNT: begin
        if (edgeCnt == CNT_LAST) begin
          strobe.latchPins = 1'b1;
          stateNext        = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (directSel) begin
          strobe.loadTarget = 1'b1;
          strobe.tgtSrc     = SRC_PINS;
          stateNext         = ST_DONE;
        end else begin
          stateNext = ST_RD2;
        end
      end
      ST_RD2: begin
        if (memAck) begin
          if (wordValid) begin
            strobe.loadTarget = 1'b1;
            strobe.tgtSrc     = SRC_BANK2;
            stateNext         = ST_DONE;
          end else begin
            stateNext = ST_RD1;
          end
        end
      end
      ST_RD1: begin
        if (memAck) begin
          strobe.loadTarget = 1'b1;
          strobe.tgtSrc     = wordValid ? SRC_BANK1 : SRC_SYSMEM;
          stateNext         = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_HOLD;
      ST_HOLD: stateNext = ST_HOLD;
      default: stateNext = ST_HOLD;
    endcase
  end

  assign memReq   = (state == ST_RD2) || (state == ST_RD1);
  assign bootDone = (state == ST_DONE);

endmodule

// File: rtl/boot_select_top.sv
module boot_select_top
  import boot_sel_pkg::*;
#(
  parameter int          LATCH_EDGE = 4,
  parameter logic [31:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0808_0000,
  parameter logic [31:0] SRAM_LO    = 32'h2000_0000,
  parameter logic [31:0] SRAM_HI    = 32'h2001_8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bootPin0,
  input  logic        bootPin1,
  input  logic        bankOptBit,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic [2:0]  bootTarget,
  output logic        bootDone
);

  ctrlStrobe_t strobe;
  logic pin0Q, pin1Q, optQ, wordValid;

  boot_sel_ctrl #(.LATCH_EDGE(LATCH_EDGE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pin0Q(pin0Q), .pin1Q(pin1Q), .optQ(optQ),
    .wordValid(wordValid), .memAck(memAck),
    .strobe(strobe), .memReq(memReq), .bootDone(bootDone)
  );

  boot_sel_dp #(
    .ADDR_W(32), .DATA_W(32),
    .BANK1_BASE(BANK1_BASE), .BANK2_BASE(BANK2_BASE),
    .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pin0In(bootPin0), .pin1In(bootPin1), .optIn(bankOptBit),
    .rdata(memRdata),
    .pin0Q(pin0Q), .pin1Q(pin1Q), .optQ(optQ),
    .wordValid(wordValid), .addr(memAddr), .target(bootTarget)
  );

endmodule

// File: rtl/boot_sel_chk.sv
module boot_sel_chk #(
  parameter logic [31:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0808_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [2:0]  bootTarget,
  input logic        bootDone
);

  logic seenDone;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenDone <= 1'b0;
    else if (bootDone) seenDone <= 1'b1;
  end

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone);

  // R1
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |-> !bootDone);

  // R1
  target_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone || seenDone) |=> $stable(bootTarget));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R9
  req_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr == BANK2_BASE || memAddr == BANK1_BASE));

  // R9
  no_req_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone || seenDone) |-> !memReq);

  // R10
  target_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bootDone && !seenDone) |-> (bootTarget == 3'd0));

  // R3
  target_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> (bootTarget >= 3'd1 && bootTarget <= 3'd5));

endmodule

bind boot_select_top boot_sel_chk #(
  .BANK1_BASE(BANK1_BASE), .BANK2_BASE(BANK2_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .bootTarget(bootTarget), .bootDone(bootDone)
);

// File: tb/boot_select_top_tb.sv
module boot_select_top_tb;

  localparam logic [31:0] B1 = 32'h0800_0000;
  localparam logic [31:0] B2 = 32'h0808_0000;
  localparam logic [31:0] LO = 32'h2000_0000;
  localparam logic [31:0] HI = 32'h2001_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootPin0 = 1'b0, bootPin1 = 1'b0, bankOptBit = 1'b1;
  logic memReq, memAck = 1'b0, bootDone;
  logic [31:0] memAddr, memRdata = '0;
  logic [2:0] bootTarget;

  int nTests = 0, nFail = 0, cycles = 0;

  always #2 clk = ~clk;

  boot_select_top u_dut (
    .clk(clk), .rstN(rstN), .bootPin0(bootPin0), .bootPin1(bootPin1),
    .bankOptBit(bankOptBit), .memReq(memReq), .memAddr(memAddr),
    .memRdata(memRdata), .memAck(memAck), .bootTarget(bootTarget),
    .bootDone(bootDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit inWin(input logic [31:0] w);
    return (w >= LO) && (w < HI);
  endfunction

  task automatic runOne(input bit opt, input bit p1, input bit p0,
                        input logic [31:0] w2, input logic [31:0] w1, input int waitC);
    int expT, expReads, nReads, doneCnt, doneCyc, waitCnt, gotT;
    logic [31:0] rd [2];
    bit direct;
    direct = opt || (p0 && p1);
    if (direct) expT = opt ? (!p0 ? 1 : (p1 ? 3 : 2)) : 3;
    else if (inWin(w2)) expT = 4;
    else if (inWin(w1)) expT = 5;
    else expT = 2;
    expReads = direct ? 0 : (inWin(w2) ? 1 : 2);
    // R2: opposite values before the capture edge
    bootPin0 = ~p0; bootPin1 = ~p1; bankOptBit = ~opt;
    memAck = 0; rstN = 0;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(bootTarget == 0 && !bootDone && !memReq, "R10 reset", bootTarget, 0);
    rstN = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bootPin0 = p0; bootPin1 = p1; bankOptBit = opt;
    @(posedge clk);
    @(negedge clk);
    // R2: values after the capture edge are ignored
    bootPin0 = ~p0; bootPin1 = ~p1; bankOptBit = ~opt;
    chk(bootTarget == 0, "R10 before done", bootTarget, 0);
    nReads = 0; doneCnt = 0; doneCyc = -1; waitCnt = 0; gotT = -1;
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      if (memAck) begin
        memAck = 0; waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt == waitC) begin
          if (nReads < 2) rd[nReads] = memAddr;
          nReads++;
          memRdata = (memAddr == B2) ? w2 : ((memAddr == B1) ? w1 : 32'hdead_beef);
          memAck = 1;
        end else waitCnt++;
      end
      if (bootDone) begin
        doneCnt++;
        if (doneCyc < 0) begin doneCyc = c; gotT = int'(bootTarget); end
      end
    end
    chk(doneCnt == 1, "R1 done count", doneCnt, 1);
    if (direct) begin
      chk(doneCyc == 1, "R1 done timing", doneCyc, 1);
      chk(gotT == expT, (opt ? "R3 pin map" : "R4 sram"), gotT, expT);
    end else if (expT == 4) chk(gotT == expT, "R5 bank2 jump", gotT, expT);
    else if (expT == 5) chk(gotT == expT, "R6 bank1 jump", gotT, expT);
    else chk(gotT == expT, "R7 fallback", gotT, expT);
    chk(bootTarget == 3'(expT), "R1 target hold", bootTarget, expT);
    chk(nReads == expReads, (direct ? "R4 no read" : "R9 read count"), nReads, expReads);
    if (nReads >= 1 && !direct) chk(rd[0] == B2, "R5 first addr", rd[0], B2);
    if (nReads >= 2 && expReads == 2) chk(rd[1] == B1, "R6 second addr", rd[1], B1);
  endtask

  initial begin
    automatic logic [31:0] words [5] = '{LO, LO - 1, HI - 1, HI, 32'h0};
    // R3 R4 direct sweep
    for (int o = 0; o < 2; o++)
      for (int pv = 0; pv < 4; pv++)
        if (o == 1 || pv == 3)
          runOne(o[0], pv[1], pv[0], LO, LO, 0);
    // R5 R6 R7 R8 R9 scan sweep
    for (int pv = 0; pv < 3; pv++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int w = 0; w < 3; w++)
            runOne(1'b0, pv[1], pv[0], words[i], words[j], w);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        nTests++; nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("[TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

endmodule